// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with One-of-Eight Demultiplex Mode

This block holds eight single-bit storage cells that are written one at a time. A three-bit selector names the target cell and a serial data bit gives its new value. Two control lines, a write block and a zeroing request, choose one of four modes for each clock edge: write a single addressed bit, hold everything, zero all bits, or act as a one-of-eight demultiplexer. In demultiplexer mode the addressed output carries the data bit and every other output is forced low. The full eight-bit word is always visible on the parallel output, whatever the control and address lines are doing.

The block is a clocked model of level-sensitive storage. Controls, address and data are sampled on the rising clock edge, and the outputs come straight from registers. A synchronous, active-high system reset sets the word to zero. It is kept separate from the zeroing request, which is a functional mode.

Top module: `lat_addr8`

## Requirements
- R1: While `sys_rst` is high at a rising edge, all bits of `q` are 0 after that edge, whatever the other inputs are.
- R2: With `zero_req`=0 and `wr_block`=0, the bit `q[bit_sel]` takes `din` at the next edge and every other bit keeps its value.
- R3: With `zero_req`=0 and `wr_block`=1, `q` keeps its value at the next edge for any `bit_sel` and `din`.
- R4: With `zero_req`=1 and `wr_block`=1, all bits of `q` are 0 after the next edge.
- R5: With `zero_req`=1 and `wr_block`=0, after the next edge `q[bit_sel]` equals `din` and all other bits are 0.
- R6: When demultiplexer mode ends and hold mode follows, `q` keeps the pattern left by the last demultiplexer edge.
- R7: `q` changes only at a rising clock edge. Input changes between edges do not show on `q` until the following edge.
- R8: A new `bit_sel` during consecutive writes moves the target to the new bit at the next edge. At most one bit changes per write edge.
- R9: A `bit_sel` value of n addresses `q[n]`, where bit 0 is the least significant bit of `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| sys_rst | input | 1 | Synchronous active-high system reset, zeroes the word |
| wr_block | input | 1 | High blocks the write path (hold or zero-all mode) |
| zero_req | input | 1 | High selects zero-all or demultiplexer mode |
| bit_sel | input | 3 | Index of the addressed bit |
| din | input | 1 | Serial data bit |
| q | output | 8 | Parallel stored word |

## Verification
The hardest case to set up is the state a demultiplexer burst leaves behind. Checking R6 requires the bits to hold a mixed pattern first, then a demultiplexer run that ends on a chosen bit and data value, and then a hold whose inputs disagree with that pattern. The stimulus builds this with directed sequences: fill the word with writes, run the demultiplexer over several addresses, end on a high or a low data bit, then hold while toggling the address and data. After that a long random run mixes all four modes with frequent address changes. Every edge is compared with a behavioural model.

// File: rtl/lat_pkg.sv
package lat_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_CLEAR = 2'd2,
        MODE_DEMUX = 2'd3
    } lat_mode_e;

    typedef struct packed {
        logic      valid;
        lat_mode_e mode;
    } lat_ctl_t;

    function automatic lat_mode_e decode_mode(input logic zero_req, input logic wr_block);
        lat_mode_e m;
        case ({zero_req, wr_block})
            2'b00:   m = MODE_WRITE;
            2'b01:   m = MODE_HOLD;
            2'b11:   m = MODE_CLEAR;
            default: m = MODE_DEMUX;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lat_mode_dec.sv
module lat_mode_dec
    import lat_pkg::*;
(
    input  logic     sys_rst,
    input  logic     zero_req,
    input  logic     wr_block,
    output lat_ctl_t ctl
);
    always_comb begin
        ctl.valid = ~sys_rst;
        ctl.mode  = decode_mode(zero_req, wr_block);
    end
endmodule

// File: rtl/lat_sel_dec.sv
module lat_sel_dec #(
    parameter int WIDTH = 8,
    parameter int SEL_W = $clog2(WIDTH)
) (
    input  logic [SEL_W-1:0] bit_sel,
    output logic [WIDTH-1:0] hit
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_hit
        assign hit[i] = (bit_sel == SEL_W'(i));
    end
endmodule

// File: rtl/lat_cell.sv
module lat_cell
    import lat_pkg::*;
(
    input  logic     clk,
    input  logic     sys_rst,
    input  lat_ctl_t ctl,
    input  logic     hit,
    input  logic     din,
    output logic     q
);
    logic q_nxt;

    always_comb begin
        q_nxt = q;
        if (ctl.valid) begin
            case (ctl.mode)
                MODE_WRITE: if (hit) q_nxt = din;
                MODE_HOLD:  q_nxt = q;
                MODE_CLEAR: q_nxt = 1'b0;
                MODE_DEMUX: q_nxt = hit & din;
                default:    q_nxt = q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (sys_rst) q <= 1'b0;
        else         q <= q_nxt;
    end
endmodule

// File: rtl/lat_addr8.sv
module lat_addr8
    import lat_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SEL_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             sys_rst,
    input  logic             wr_block,
    input  logic             zero_req,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    lat_ctl_t         ctl;
    logic [WIDTH-1:0] hit;

    lat_mode_dec u_mode (
        .sys_rst  (sys_rst),
        .zero_req (zero_req),
        .wr_block (wr_block),
        .ctl      (ctl)
    );

    lat_sel_dec #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_sel (
        .bit_sel (bit_sel),
        .hit     (hit)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        lat_cell u_cell (
            .clk     (clk),
            .sys_rst (sys_rst),
            .ctl     (ctl),
            .hit     (hit[i]),
            .din     (din),
            .q       (q[i])
        );
    end
endmodule

// File: rtl/lat_addr8_chk.sv
module lat_addr8_chk #(
    parameter int WIDTH = 8,
    parameter int SEL_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             sys_rst,
    input logic             wr_block,
    input logic             zero_req,
    input logic [SEL_W-1:0] bit_sel,
    input logic             din,
    input logic [WIDTH-1:0] q
);
    AST_SYSRST_ZERO: assert property (@(posedge clk)
        sys_rst |=> (q == '0)); // R1

    AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (sys_rst)
        (!zero_req && !wr_block) |=> (q[$past(bit_sel)] == $past(din))); // R2

    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (sys_rst)
        (!zero_req && !wr_block) |=> ($countones(q ^ $past(q)) <= 1)); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (sys_rst)
        (!zero_req && wr_block) |=> $stable(q)); // R3

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (sys_rst)
        (zero_req && wr_block) |=> (q == '0)); // R4

    AST_DEMUX_PATTERN: assert property (@(posedge clk) disable iff (sys_rst)
        (zero_req && !wr_block) |=>
        (q == ($past(din) ? (WIDTH'(1) << $past(bit_sel)) : WIDTH'(0)))); // R5

    AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (sys_rst)
        (zero_req && !wr_block) |=> $onehot0(q)); // R5
endmodule

bind lat_addr8 lat_addr8_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .sys_rst  (sys_rst),
    .wr_block (wr_block),
    .zero_req (zero_req),
    .bit_sel  (bit_sel),
    .din      (din),
    .q        (q)
);

// File: tb/lat_addr8_tb.sv
module lat_addr8_tb;
    logic       clk = 1'b0;
    logic       sys_rst = 1'b1;
    logic       wr_block = 1'b1;
    logic       zero_req = 1'b0;
    logic [2:0] bit_sel = 3'd0;
    logic       din = 1'b0;
    logic [7:0] q;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string tag = "R1";
    logic [7:0] model = 8'h00;

    always #2.5 clk = ~clk;

    lat_addr8 u_dut (
        .clk(clk), .sys_rst(sys_rst), .wr_block(wr_block), .zero_req(zero_req),
        .bit_sel(bit_sel), .din(din), .q(q)
    );

    // behavioural reference model
    always @(posedge clk) begin
        cycles++;
        if (sys_rst) model <= 8'h00;
        else if (zero_req && wr_block) model <= 8'h00;
        else if (zero_req) begin
            model <= 8'h00;
            model[bit_sel] <= din;
        end else if (!wr_block) model[bit_sel] <= din;
    end

    task automatic check(input string t);
        n_vec++;
        if (q !== model) begin
            n_bad++;
            $display("FAIL %s: q=%b expected %b at cycle %0d", t, q, model, cycles);
        end
    endtask

    // compare the result of the last edge, then apply the next inputs
    task automatic step(input logic zr, input logic wb, input logic [2:0] s,
                        input logic d, input string t);
        @(negedge clk);
        check(tag);
        sys_rst = 1'b0; zero_req = zr; wr_block = wb; bit_sel = s; din = d;
        tag = t;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1");
        // R9 / R2: walk writes of 1 upward, then a pattern
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 3'(i), 1'b1, "R9");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 3'(i), i[0], "R2");
        // R3: hold with toggling address and data
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 3'(7 - i), ~i[0], "R3");
        // R8: address changes on every write edge
        step(1'b0, 1'b0, 3'd2, 1'b1, "R8");
        step(1'b0, 1'b0, 3'd5, 1'b0, "R8");
        step(1'b0, 1'b0, 3'd0, 1'b1, "R8");
        // R7: input changes between edges must not reach q
        @(negedge clk);
        check(tag);
        sys_rst = 1'b0; zero_req = 1'b1; wr_block = 1'b1; din = 1'b1; tag = "R4";
        #1 check("R7");
        bit_sel = 3'd6; zero_req = 1'b0;
        #0.5 check("R7");
        zero_req = 1'b1;
        // R4 after a filled word
        step(1'b0, 1'b0, 3'd3, 1'b1, "R2");
        step(1'b1, 1'b1, 3'd3, 1'b1, "R4");
        // R5: demux across addresses, then R6 hold after ending high
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'(i), ~i[1], "R5");
        step(1'b1, 1'b0, 3'd6, 1'b1, "R5");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 3'(i), 1'b0, "R6");
        // R6 ending low leaves all zero
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 3'(i), 1'b1, "R2");
        step(1'b1, 1'b0, 3'd4, 1'b0, "R5");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 3'(i + 4), 1'b1, "R6");
        // R1 mid-run with write active
        @(negedge clk);
        check(tag);
        sys_rst = 1'b1; zero_req = 1'b0; wr_block = 1'b0; bit_sel = 3'd1; din = 1'b1;
        tag = "R1";
        // random mix of all modes
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            case (r)
                0:       step(1'b1, 1'b1, 3'($urandom), 1'($urandom), "R4");
                1, 2:    step(1'b1, 1'b0, 3'($urandom), 1'($urandom), "R5");
                3, 4:    step(1'b0, 1'b1, 3'($urandom), 1'($urandom), "R3");
                default: step(1'b0, 1'b0, 3'($urandom), 1'($urandom), "R8");
            endcase
        end
        @(negedge clk);
        check(tag);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule